// File: doc/BRIEF.md
# Sensor Row Bias Correction Engine

This engine captures a full frame from an external light-sensor array, one row at a time, into an on-chip pixel buffer. Each row arrives as a stream of bytes. The first bytes are image pixels. The two bytes that follow them come from masked pixels that receive no light, so they show the row's black level. When a row is complete, the engine derives a bias from those two reference bytes. It then walks the stored row column by column and removes the bias from every pixel. It moves on row by row until the whole frame is corrected, and then goes back to idle.

A host processor controls the engine over a shared strobe bus. This bus has a 16-bit address, separate one-cycle read and write strobes, and 8-bit data. Writing 1 to the command address starts a capture. The host polls a status address until the finished bit is set, then reads the corrected pixels directly out of the buffer. The sensor side uses a simple handshake: the engine raises a ready output while it wants row bytes, and a byte moves on each clock where both ready and the sensor's valid input are high.

Top module: `rbc_top`

## Requirements
- R1: After reset, `pix_ready` is 0, `bus_rdata` is 0 and a read of the status address returns 0.
- R2: A write strobe to the command address (default 16'hF000) with data bit 0 set starts a capture when the engine is idle, and `pix_ready` rises in the next cycle. A write with bit 0 clear has no effect.
- R3: A sensor byte is taken only on a clock edge where both `pix_valid` and `pix_ready` are high. Each row takes 66 bytes. Bytes 0..63 are stored in columns 0..63 of the current row, and bytes 64 and 65 are the two dark reference pixels.
- R4: The bias of a row is the sum of its two reference bytes shifted right by one, which is the floor of their mean.
- R5: Each stored pixel p of a row is replaced by p minus bias when p is at least the bias, and by 0 otherwise. The result is kept as an unsigned 8-bit value.
- R6: Rows are filled and corrected in order from 0 to 63. After row 63 the engine goes idle, drops `pix_ready` and sets the finished status bit.
- R7: A read strobe at address A below 16'h1000 returns, in the next cycle on `bus_rdata`, the pixel at row A[11:6], column A[5:0]. In any cycle that does not follow a read strobe, `bus_rdata` is 0.
- R8: A read of the status address (default 16'hF001) returns bit 0 = finished and bit 1 = busy, with all other bits 0. Finished and busy are never both set.
- R9: A start write received while a capture is running is ignored. The capture continues with its row order unchanged.
- R10: Starting a new capture clears the finished bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Sensor byte on `pix_data` is valid |
| pix_data | input | 8 | Sensor byte |
| pix_ready | output | 1 | Engine is taking row bytes |
| bus_addr | input | 16 | Host bus address |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid the cycle after `bus_rd` |

## Verification
The bench captures two frames. Each frame mixes rows of pseudo-random pixels with rows whose reference pair is chosen on purpose. A pair of (0,0) must leave the row unchanged. A pair of (255,255) must clear every pixel. An odd sum such as (1,2) or (3,0) separates floor rounding from rounding up. A pair of (200,201) causes heavy saturation at zero, so it separates clamping from wraparound. Because every row has distinct content, rows stored in the wrong order or at the wrong place are caught. Idle valid cycles carrying a junk byte separate correct handshake acceptance from taking every byte. A start write in the middle of a capture, and the second frame, show whether a restart is ignored and whether the finished bit is cleared.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int PIX_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET,
    ST_BIAS,
    ST_FIX,
    ST_NEXT
  } rbc_state_e;

  // floor of the mean of the two dark reference pixels
  function automatic logic [PIX_W-1:0] rbc_bias(input logic [PIX_W-1:0] d0,
                                                input logic [PIX_W-1:0] d1);
    logic [PIX_W:0] sum;
    sum = {1'b0, d0} + {1'b0, d1};
    return sum[PIX_W:1];
  endfunction

  // subtract clamped at zero
  function automatic logic [PIX_W-1:0] rbc_sat_sub(input logic [PIX_W-1:0] p,
                                                   input logic [PIX_W-1:0] b);
    return (p >= b) ? (p - b) : '0;
  endfunction
endpackage

// File: rtl/rbc_buffer.sv
module rbc_buffer #(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int PIX_W = 8,
  localparam int DEPTH = ROWS * COLS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic [AW-1:0]    ra_addr,
  output logic [PIX_W-1:0] ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [PIX_W-1:0] rb_data
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/rbc_ctrl.sv
module rbc_ctrl
  import rbc_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int CCW = $clog2(COLS + 2),
  localparam int AW  = RW + CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             buf_we,
  output logic [AW-1:0]    buf_waddr,
  output logic [PIX_W-1:0] buf_wdata,
  output logic [AW-1:0]    fix_raddr,
  input  logic [PIX_W-1:0] fix_rdata,
  output logic             busy,
  output logic             done
);
  localparam logic [CCW-1:0] COL_D0   = CCW'(COLS);
  localparam logic [CCW-1:0] COL_D1   = CCW'(COLS + 1);
  localparam logic [CCW-1:0] COL_LAST = CCW'(COLS - 1);
  localparam logic [RW-1:0]  ROW_LAST = RW'(ROWS - 1);

  rbc_state_e       state_q;
  logic [RW-1:0]    row_q;
  logic [CCW-1:0]   col_q;
  logic [PIX_W-1:0] dk0_q, dk1_q, bias_q;
  logic             done_q;

  // named internal events
  logic pix_accept, pix_store, fix_we, row_last, col_end;
  assign pix_accept = (state_q == ST_GET) && pix_valid;
  assign pix_store  = pix_accept && (col_q < COL_D0);
  assign fix_we     = (state_q == ST_FIX);
  assign row_last   = (row_q == ROW_LAST);
  assign col_end    = (col_q == COL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      dk0_q   <= '0;
      dk1_q   <= '0;
      bias_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_GET;
            row_q   <= '0;
            col_q   <= '0;
            done_q  <= 1'b0;
          end
        end
        ST_GET: begin
          if (pix_accept) begin
            if (col_q == COL_D0) dk0_q <= pix_data;
            if (col_q == COL_D1) begin
              dk1_q   <= pix_data;
              col_q   <= '0;
              state_q <= ST_BIAS;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end
        end
        ST_BIAS: begin
          bias_q  <= rbc_bias(dk0_q, dk1_q);
          state_q <= ST_FIX;
        end
        ST_FIX: begin
          if (col_end) begin
            col_q   <= '0;
            state_q <= ST_NEXT;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ST_NEXT: begin
          if (row_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            row_q   <= row_q + 1'b1;
            state_q <= ST_GET;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pix_ready = (state_q == ST_GET);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign buf_we    = pix_store || fix_we;
  assign buf_waddr = {row_q, col_q[CW-1:0]};
  assign fix_raddr = {row_q, col_q[CW-1:0]};
  assign buf_wdata = fix_we ? rbc_sat_sub(fix_rdata, bias_q) : pix_data;

  // R2: an idle start moves straight into row loading
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start) |=> (state_q == ST_GET && row_q == '0));

  // R4: the bias lies between the two reference pixels
  a_r4_bias_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIX) |->
      ((dk0_q <= dk1_q) ? (bias_q >= dk0_q && bias_q <= dk1_q)
                        : (bias_q >= dk1_q && bias_q <= dk0_q)));

  // R5: a corrected pixel never exceeds the stored one (no wraparound)
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> (buf_wdata <= fix_rdata));

  // R6: after the last row the engine is idle and finished
  a_r6_last_row_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NEXT && row_last) |=> (state_q == ST_IDLE && done_q && !pix_ready));

  // R9: a start during a running row leaves the row index alone
  a_r9_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state_q == ST_GET || state_q == ST_BIAS || state_q == ST_FIX))
      |=> (row_q == $past(row_q)));
endmodule

// File: rtl/rbc_host.sv
module rbc_host
  import rbc_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              ROWS      = 64,
  parameter int              COLS      = 64,
  parameter logic [ADDR_W-1:0] BUF_BASE  = 16'h0000,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'hF000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hF001,
  localparam int AW = $clog2(ROWS * COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PIX_W-1:0]  bus_wdata,
  output logic [PIX_W-1:0]  bus_rdata,
  output logic              start,
  input  logic              busy,
  input  logic              done,
  output logic [AW-1:0]     host_raddr,
  input  logic [PIX_W-1:0]  host_rdata
);
  logic buf_hit, stat_hit, cmd_hit;
  logic [PIX_W-1:0] stat_word, rd_mux, rdata_q;

  assign buf_hit  = (bus_addr[ADDR_W-1:AW] == BUF_BASE[ADDR_W-1:AW]);
  assign stat_hit = (bus_addr == STAT_ADDR);
  assign cmd_hit  = (bus_addr == CMD_ADDR);

  assign start      = bus_wr && cmd_hit && bus_wdata[0];
  assign host_raddr = bus_addr[AW-1:0];
  assign stat_word  = {{(PIX_W-2){1'b0}}, busy, done};

  always_comb begin
    rd_mux = '0;
    if (buf_hit)       rd_mux = host_rdata;
    else if (stat_hit) rd_mux = stat_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_rd ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;

  // R7: read data is zero except in the cycle after a read strobe
  a_r7_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

  // R8: finished and busy are exclusive
  a_r8_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: rtl/rbc_top.sv
module rbc_top
  import rbc_pkg::*;
#(
  parameter int              ROWS      = 64,
  parameter int              COLS      = 64,
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BUF_BASE  = 16'h0000,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'hF000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hF001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              pix_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PIX_W-1:0]  bus_wdata,
  output logic [PIX_W-1:0]  bus_rdata
);
  localparam int AW = $clog2(ROWS * COLS);

  logic             start, busy, done, buf_we;
  logic [AW-1:0]    buf_waddr, fix_raddr, host_raddr;
  logic [PIX_W-1:0] buf_wdata, fix_rdata, host_rdata;

  rbc_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_ready (pix_ready),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_wdata (buf_wdata),
    .fix_raddr (fix_raddr),
    .fix_rdata (fix_rdata),
    .busy      (busy),
    .done      (done)
  );

  rbc_buffer #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W)) u_buf (
    .clk     (clk),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .ra_addr (fix_raddr),
    .ra_data (fix_rdata),
    .rb_addr (host_raddr),
    .rb_data (host_rdata)
  );

  rbc_host #(
    .ADDR_W(ADDR_W), .ROWS(ROWS), .COLS(COLS),
    .BUF_BASE(BUF_BASE), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .host_raddr (host_raddr),
    .host_rdata (host_rdata)
  );
endmodule

// File: tb/sim_rbc_top.sv
module sim_rbc_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam logic [15:0] CMD  = 16'hF000;
  localparam logic [15:0] STAT = 16'hF001;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = 8'h00;
  logic       pix_ready;
  logic [15:0] bus_addr = 16'h0000;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int gap_k = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rbc_top u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [7:0] next_byte();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0] ^ lfsr[15:8];
  endfunction

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic host_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // driver: sends one row, pushing the expected corrected pixels
  task automatic send_row(input int r, input int cap);
    logic [7:0] px [COLS+2];
    int bias;
    for (int c = 0; c < COLS; c++)
      px[c] = (cap == 1 && r == 5) ? 8'(c * 4) : next_byte();
    case (r % 8)
      0: begin px[COLS] = 8'd0;   px[COLS+1] = 8'd0;   end
      1: begin px[COLS] = 8'd255; px[COLS+1] = 8'd255; end
      2: begin px[COLS] = 8'd1;   px[COLS+1] = 8'd2;   end
      3: begin px[COLS] = 8'd3;   px[COLS+1] = 8'd0;   end
      4: begin px[COLS] = 8'd200; px[COLS+1] = 8'd201; end
      default: begin px[COLS] = next_byte() >> 2; px[COLS+1] = next_byte() >> 2; end
    endcase
    bias = (int'(px[COLS]) + int'(px[COLS+1])) / 2;
    for (int c = 0; c < COLS; c++) begin
      int v;
      v = int'(px[c]) - bias;
      exp_q.push_back((v < 0) ? 8'd0 : 8'(v));
    end
    for (int b = 0; b < COLS + 2; b++) begin
      bit sent;
      sent = 1'b0;
      while (!sent) begin
        @(negedge clk);
        gap_k++;
        if (gap_k % 5 == 3) begin
          pix_valid = 1'b0; pix_data = 8'hEE;   // junk while not valid (R3)
        end else if (pix_ready) begin
          pix_valid = 1'b1; pix_data = px[b]; sent = 1'b1;
        end else begin
          pix_valid = 1'b0;
        end
      end
    end
    @(negedge clk);
    pix_valid = 1'b0; pix_data = 8'hEE;
  endtask

  // monitor: reads the corrected frame and compares against the queue
  task automatic check_frame();
    logic [7:0] d;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        logic [7:0] e;
        host_read(16'(r * COLS + c), d);
        e = exp_q.pop_front();
        check($sformatf("R5/R4/R3/R6 pixel r%0d c%0d", r, c), d, e);
      end
    end
    @(negedge clk);
    check("R7 rdata zero after read", bus_rdata, 0);
  endtask

  task automatic wait_done();
    logic [7:0] s;
    s = 8'h00;
    while (!s[0]) host_read(STAT, s);
    check("R6 finished status", s, 8'h01);
    check("R6 pix_ready low when idle", pix_ready, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pix_ready after reset", pix_ready, 0);
    check("R1 rdata after reset", bus_rdata, 0);
    host_read(STAT, s);
    check("R1 status after reset", s, 0);
    // R2 write of zero does nothing
    host_write(CMD, 8'h00);
    @(negedge clk);
    check("R2 zero write no start", pix_ready, 0);
    host_read(STAT, s);
    check("R2 zero write status", s, 0);
    // R2 start
    host_write(CMD, 8'h01);
    check("R2 pix_ready after start", pix_ready, 1);

    for (int cap = 0; cap < 2; cap++) begin
      if (cap == 1) begin
        host_write(CMD, 8'h01);
        host_read(STAT, s);
        check("R10 finished cleared on restart", s, 8'h02);
      end
      fork
        begin
          for (int r = 0; r < ROWS; r++) send_row(r, cap);
        end
        begin
          logic [7:0] st;
          repeat (3000) @(negedge clk);
          host_write(CMD, 8'h01);   // R9 restart attempt mid capture
          host_read(STAT, st);
          check("R8 status while busy", st, 8'h02);
        end
      join
      wait_done();
      check_frame();
    end
    summary();
    $finish;
  end
endmodule